// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands over several clock cycles and returns their full 2N-bit signed product. It holds a single working register of 2N+1 bits. The upper N bits are the accumulator, the middle N bits start out as the multiplier, and one extra bit sits at the bottom, to the right of the multiplier.

On every step the two lowest bits of that register are recoded into one of three actions:
- subtract the multiplicand from the accumulator,
- add the multiplicand to the accumulator,
- leave the accumulator unchanged.

After the action, the whole register shifts right by one place and copies its sign into the top. A run of ones in the multiplier therefore costs one subtract where the run begins and one add just past its end. Signed operands need no correction step at the end.

A user pulses `start` while the block is idle, with both operands on the inputs. `busy` is then high for exactly N cycles. `done` pulses for one cycle when the product is ready. The product stays on its output until the next accepted start.

Top module: `booth_mult`

## Requirements
- R1: While and after reset (before any start), `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is high for exactly N cycles after the accepting edge. `done` is high in the cycle after the last busy cycle, which is N+1 cycles after the accepting edge.
- R3: A `start` sampled while `busy` is 1 is ignored. The running operation keeps its result and its timing.
- R4: When `done` is high, `product` equals the signed product of the two operands captured at the accepting edge, as a 2N-bit two's-complement value. With N = 4, 2 × 7 gives 8'h0E and 2 × −3 gives 8'hFA.
- R5: The most negative operand value is handled correctly in either position. With N = 4, −8 × −8 gives 8'h40, −8 × 7 gives 8'hC8 and 7 × −8 gives 8'hC8.
- R6: While the block is idle and no start is accepted, `product` does not change.
- R7: The operand inputs are sampled only at the accepting edge. Changing them while `busy` is 1 does not change the result.
- R8: `done` is a single-cycle pulse, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand |
| multiplier | input | N | Signed multiplier |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Signed 2N-bit product |

## Verification
The bound checker watches the handshake on every cycle:
- the length of each busy period, counted against N;
- that `done` is a one-cycle pulse exclusive with `busy`;
- that the output holds while idle;
- that each `done` product matches the signed product of the operands it captured.

Only the bench's scenarios can show other behaviour:
- that arithmetic is correct over the entire N = 4 operand space, including the most negative values;
- that random N = 32 pairs are correct;
- that a second start during a run, or operands that change mid-run, leave the result and the latency untouched.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        BOOTH_NOP = 2'd0,
        BOOTH_ADD = 2'd1,
        BOOTH_SUB = 2'd2
    } booth_op_e;

    typedef struct packed {
        logic load;
        logic step;
        logic last;
    } booth_ctrl_s;

    // pair = {current multiplier bit, bit to its right}
    function automatic booth_op_e booth_decode(input logic cur, input logic right);
        case ({cur, right})
            2'b10:   return BOOTH_SUB;
            2'b01:   return BOOTH_ADD;
            default: return BOOTH_NOP;
        endcase
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      right_bit,
    output booth_op_e op
);
    always_comb begin
        op = booth_decode(cur_bit, right_bit);
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N-1:0] sum,
    output logic         ext
);
    logic [N-1:0] operand_b;
    logic         carry_in;
    logic [N:0]   raw;

    always_comb begin
        operand_b = (op == BOOTH_SUB) ? ~mcand : mcand;
        carry_in  = (op == BOOTH_SUB);
        raw       = {1'b0, acc} + {1'b0, operand_b} + {{N{1'b0}}, carry_in};
        if (op == BOOTH_NOP) begin
            sum = acc;
            ext = acc[N-1];
        end else begin
            sum = raw[N-1:0];
            // true sign of the (N+1)-bit sign-extended sum
            ext = acc[N-1] ^ operand_b[N-1] ^ raw[N];
        end
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output booth_ctrl_s ctl
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] step_cnt;

    always_comb begin
        ctl.load = start && !busy;
        ctl.step = busy;
        ctl.last = busy && (step_cnt == CW'(N - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            step_cnt <= '0;
        end else begin
            done <= ctl.last;
            if (ctl.load) begin
                busy     <= 1'b1;
                step_cnt <= '0;
            end else if (ctl.last) begin
                busy     <= 1'b0;
                step_cnt <= '0;
            end else if (busy) begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int RW = 2 * N + 1;

    booth_ctrl_s   ctl;
    booth_op_e     op;
    logic [RW-1:0] work;
    logic [N-1:0]  mcand_q;
    logic [N-1:0]  new_upper;
    logic          new_ext;

    booth_ctrl #(.N(N)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .ctl   (ctl)
    );

    booth_recoder i_rec (
        .cur_bit   (work[1]),
        .right_bit (work[0]),
        .op        (op)
    );

    booth_addsub #(.N(N)) i_alu (
        .acc   (work[RW-1:N+1]),
        .mcand (mcand_q),
        .op    (op),
        .sum   (new_upper),
        .ext   (new_ext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work    <= '0;
            mcand_q <= '0;
        end else if (ctl.load) begin
            work    <= {{N{1'b0}}, multiplier, 1'b0};
            mcand_q <= multiplicand;
        end else if (ctl.step) begin
            work    <= {new_ext, new_upper, work[N:1]};
        end
    end

    assign product = work[RW-1:1];
endmodule

// File: rtl/booth_mult_checker.sv
module booth_mult_checker #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   multiplicand,
    input logic [N-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int KW = $clog2(N + 1) + 1;

    logic [KW-1:0]         busy_len;
    logic signed [N-1:0]   a_q;
    logic signed [N-1:0]   b_q;
    logic signed [2*N-1:0] ref_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            a_q      <= '0;
            b_q      <= '0;
        end else begin
            busy_len <= busy ? busy_len + 1'b1 : '0;
            if (start && !busy) begin
                a_q <= multiplicand;
                b_q <= multiplier;
            end
        end
    end

    always_comb begin
        ref_prod = a_q * b_q;
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == KW'(N)));

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < KW'(N)));

    p_result_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_prod));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind booth_mult booth_mult_checker #(.N(N)) i_booth_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/test_booth_mult.sv
`timescale 1ns/1ps
module test_booth_mult;
    localparam int W = 32;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic           st_w, st_s;
    logic [W-1:0]   a_w, b_w;
    logic [S-1:0]   a_s, b_s;
    logic           busy_w, done_w, busy_s, done_s;
    logic [2*W-1:0] p_w;
    logic [2*S-1:0] p_s;

    booth_mult #(.N(W)) i_booth_mult (
        .clk(clk), .rst(rst), .start(st_w), .multiplicand(a_w), .multiplier(b_w),
        .busy(busy_w), .done(done_w), .product(p_w)
    );

    booth_mult #(.N(S)) i_booth_mult_n4 (
        .clk(clk), .rst(rst), .start(st_s), .multiplicand(a_s), .multiplier(b_s),
        .busy(busy_s), .done(done_s), .product(p_s)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // run on the 4-bit instance; returns product and latency in cycles
    task automatic run4(input logic [S-1:0] a, input logic [S-1:0] b,
                        output logic [2*S-1:0] p, output int lat);
        @(negedge clk);
        a_s = a; b_s = b; st_s = 1'b1;
        @(negedge clk);
        st_s = 1'b0;
        lat = 1;
        while (!done_s && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        p = p_s;
    endtask

    task automatic run32(input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [2*W-1:0] p, output int lat);
        @(negedge clk);
        a_w = a; b_w = b; st_w = 1'b1;
        @(negedge clk);
        st_w = 1'b0;
        lat = 1;
        while (!done_w && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        p = p_w;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy_w && !done_w && p_w == '0, "R1 reset 32", {62'd0, busy_w, done_w}, 64'd0);
        check(!busy_s && !done_s && p_s == '0, "R1 reset 4", {56'd0, p_s}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_w && !done_w && p_w == '0, "R1 after reset", p_w, 64'd0);
    endtask

    task automatic t_examples();
        logic [2*S-1:0] p;
        int lat;
        run4(4'd2, 4'd7, p, lat);
        check(p == 8'h0E, "R4 2x7", {56'd0, p}, 64'h0E);
        check(lat == S + 1, "R2 latency n4", lat, S + 1);
        run4(4'd2, 4'hD, p, lat);
        check(p == 8'hFA, "R4 2x-3", {56'd0, p}, 64'hFA);
        check(done_s == 1'b1 && busy_s == 1'b0, "R8 done without busy", {62'd0, busy_s, done_s}, 64'd1);
        @(negedge clk);
        check(done_s == 1'b0, "R8 done single pulse", {63'd0, done_s}, 64'd0);
    endtask

    task automatic t_min_neg();
        logic [2*S-1:0] p;
        int lat;
        run4(4'h8, 4'h8, p, lat);
        check(p == 8'h40, "R5 -8x-8", {56'd0, p}, 64'h40);
        run4(4'h8, 4'h7, p, lat);
        check(p == 8'hC8, "R5 -8x7", {56'd0, p}, 64'hC8);
        run4(4'h7, 4'h8, p, lat);
        check(p == 8'hC8, "R5 7x-8", {56'd0, p}, 64'hC8);
    endtask

    task automatic t_exhaustive();
        logic [2*S-1:0] p;
        int lat;
        int bad = 0;
        logic [2*S-1:0] e;
        logic [2*S-1:0] first_act = '0, first_exp = '0;
        for (int ai = -8; ai < 8; ai++) begin
            for (int bi = -8; bi < 8; bi++) begin
                run4(S'(ai), S'(bi), p, lat);
                e = 8'(ai * bi);
                if (p !== e || lat != S + 1) begin
                    if (bad == 0) begin first_act = p; first_exp = e; end
                    bad++;
                end
            end
        end
        check(bad == 0, "R4 exhaustive n4", {56'd0, first_act}, {56'd0, first_exp});
    endtask

    task automatic t_random();
        logic [2*W-1:0] p;
        int lat;
        logic signed [W-1:0] a, b;
        logic signed [2*W-1:0] e;
        int bad = 0;
        logic [63:0] fa = '0, fe = '0;
        for (int k = 0; k < 200; k++) begin
            a = $signed(W'($urandom));
            b = $signed(W'($urandom));
            if (k == 0) begin a = 32'h8000_0000; b = 32'h8000_0000; end
            if (k == 1) begin a = 32'h8000_0000; b = 32'h7FFF_FFFF; end
            if (k == 2) begin a = 32'hFFFF_FFFF; b = 32'h0000_0001; end
            e = a * b;
            run32(a, b, p, lat);
            if (p !== e || lat != W + 1) begin
                if (bad == 0) begin fa = p; fe = e; end
                bad++;
            end
        end
        check(bad == 0, "R4 R5 random n32", fa, fe);
    endtask

    task automatic t_busy_ignore();
        int lat = 1;
        @(negedge clk);
        a_w = 32'd1234; b_w = -32'sd77; st_w = 1'b1;
        @(negedge clk);
        st_w = 1'b0;
        @(negedge clk);
        lat++;
        a_w = 32'd5; b_w = 32'd9; st_w = 1'b1;
        @(negedge clk);
        lat++;
        st_w = 1'b0;
        while (!done_w && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(p_w == 64'(-95018), "R3 start while busy ignored", p_w, 64'(-95018));
        check(lat == W + 1, "R3 latency unchanged", lat, W + 1);
    endtask

    task automatic t_operand_change();
        int lat = 1;
        @(negedge clk);
        a_w = -32'sd3000; b_w = 32'd41; st_w = 1'b1;
        @(negedge clk);
        st_w = 1'b0;
        a_w = 32'hFFFF; b_w = 32'h1234;
        while (!done_w && lat < 200) begin
            @(negedge clk);
            lat++;
            a_w = ~a_w;
        end
        check(p_w == 64'(-123000), "R7 operands changed mid-run", p_w, 64'(-123000));
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        keep = p_w;
        a_w = 32'd7; b_w = 32'd7;
        for (int k = 0; k < 5; k++) @(negedge clk);
        check(p_w == keep && !busy_w, "R6 product held while idle", p_w, keep);
    endtask

    initial begin
        st_w = 1'b0; st_s = 1'b0; a_w = '0; b_w = '0; a_s = '0; b_s = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_examples();
        t_min_neg();
        t_exhaustive();
        t_random();
        t_busy_ignore();
        t_operand_change();
        t_hold();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 run did not complete actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule